// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is the serial front end of a small peripheral that holds a handful of byte registers. It watches the open-drain SCL and SDA lines through a two-flop synchronizer and a glitch filter, then finds START, repeated START and STOP conditions. After a START it takes in one identification byte. That byte must carry a fixed five-bit prefix and the levels of two board strap pins. When the byte matches, the block acknowledges it and goes on to either a write transaction or a read transaction.

In a write, the block takes an address byte and one data byte. It hands them to the register controller as a single-cycle commit pulse. In a read, the master first writes the address. It then issues a repeated START and a read identification byte. The block then streams register bytes for as long as the master keeps acknowledging, and the register address advances after every byte. The block only ever pulls SDA low: for acknowledges and for zero data bits. It gives the controller a one-cycle pulse for every STOP. While the power-up recall is still running (`ready` low), the block ignores all bus traffic.

Top module: `pinaddr_i2c_slave`

## Requirements
- R1: An identification byte is accepted when its bits [7:3] equal 01010 and its bits [2:1] equal `strap[1:0]` (`strap[1]` in bit 2). Bit 0 selects the direction (1 = read, 0 = write). Bytes arrive MSB first. An accepted byte is acknowledged by pulling SDA low for the whole ninth SCL clock.
- R2: A mismatching identification byte is not acknowledged. No later byte is acknowledged or committed until the next START.
- R3: A write consists of START, an identification byte with R/W=0, an address byte and a data byte. All three bytes are acknowledged. On the data byte, `wr_stb` pulses for one clock with `wr_addr` equal to bits [1:0] of the address byte and `wr_data` equal to the data byte.
- R4: Only one data byte is taken per write. Any further byte before STOP is neither acknowledged nor committed.
- R5: A read is a write of the address, then a repeated START, then an identification byte with R/W=1. After that, the block sends the byte at `rd_addr`, MSB first. After each master ACK the address advances by one, and it wraps from 2 to 0.
- R6: A master NACK ends a read. SDA stays released on every later SCL clock.
- R7: Every STOP (SDA rising while SCL is high) produces a single-cycle `stop_stb` pulse.
- R8: While `ready` is low, the block ignores START and STOP. It gives no ACK, no `wr_stb` and no `stop_stb`.
- R9: A pulse on SCL or SDA shorter than FILT system clocks has no effect. An SDA pulse of that kind while SCL is high is not taken as START or STOP.
- R10: After reset, SDA is released and `wr_stb` and `stop_stb` are low.
- R11: While `ready` stays high, the SDA pull-down changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | input | 1 | High once the power-up recall has finished |
| strap | input | 2 | Strap pin levels; strap[1] is compared with ID bit 2 and strap[0] with ID bit 1 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| rd_addr | output | 2 | Register address for the read port |
| rd_data | input | 8 | Register byte at rd_addr |
| wr_stb | output | 1 | One-cycle write commit |
| wr_addr | output | 2 | Address of the write commit |
| wr_data | output | 8 | Data of the write commit |
| stop_stb | output | 1 | One-cycle pulse when a STOP is seen |

## Verification
The checks assume that `ready` never falls while the block is pulling SDA. They also assume the master changes SDA while SCL is high only to form a START or a STOP. The stimulus keeps to both: it raises `ready` once, and it places every SDA change in the middle of an SCL low phase. It also spaces every line edge 20 system clocks apart, which is far above the synchronizer and filter latency. Because of that spacing, every edge the block sees is a deliberate one, with one exception: the short SDA pulse injected on purpose to exercise the filter.

// File: rtl/pinaddr_i2c_slave.sv
module pinaddr_i2c_slave #(
  parameter int FILT = 3,
  parameter int AW = 2,
  parameter logic [AW-1:0] LAST = 2,
  parameter logic [4:0] PREFIX = 5'b01010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic [1:0]    strap,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          stop_stb
);
  localparam int CW = $clog2(FILT + 1);
  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_WDATA, S_TX} st_t;

  logic [1:0] m1, m2, flt, fq;
  logic [CW-1:0] cnt [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= '1; m2 <= '1; flt <= '1; fq <= '1;
      cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      m1 <= {scl_i, sda_i};
      m2 <= m1;
      fq <= flt;
      for (int i = 0; i < 2; i++)
        if (m2[i] == flt[i]) cnt[i] <= '0;
        else if (cnt[i] == CW'(FILT - 1)) begin
          flt[i] <= m2[i];
          cnt[i] <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
    end

  logic scl_f, sda_f, rise, fall, start, stop;
  assign scl_f = flt[1];
  assign sda_f = flt[0];
  assign rise  = scl_f & ~fq[1];
  assign fall  = ~scl_f & fq[1];
  assign start = scl_f & fq[1] & fq[0] & ~sda_f;
  assign stop  = scl_f & fq[1] & ~fq[0] & sda_f;

  st_t st;
  logic [3:0] bcnt;
  logic [7:0] sh;
  logic ackph, drv;
  logic [AW-1:0] addr;

  wire id_ok = sh[7:1] == {PREFIX, strap};
  wire [AW-1:0] nxt_addr = (addr == LAST) ? '0 : addr + 1'b1;

  assign sda_pull = drv;
  assign rd_addr  = addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; ackph <= 1'b0; drv <= 1'b0;
      addr <= '0; wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; stop_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      stop_stb <= 1'b0;
      if (!ready) begin
        st <= S_IDLE; ackph <= 1'b0; drv <= 1'b0;
      end else if (start) begin
        st <= S_ID; bcnt <= '0; ackph <= 1'b0; drv <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; ackph <= 1'b0; drv <= 1'b0; stop_stb <= 1'b1;
      end else if (rise) begin
        if (ackph) begin
          if (st == S_TX && !drv) begin
            if (sda_f) st <= S_IDLE;
            else addr <= nxt_addr;
          end
        end else if (st != S_IDLE && bcnt < 4'd8) begin
          sh <= {sh[6:0], sda_f};
          bcnt <= bcnt + 1'b1;
        end
      end else if (fall) begin
        if (ackph) begin
          ackph <= 1'b0;
          bcnt <= '0;
          if (st == S_TX) begin
            sh <= rd_data;
            drv <= ~rd_data[7];
          end else drv <= 1'b0;
        end else if (bcnt == 4'd8 && st != S_IDLE) begin
          ackph <= 1'b1;
          case (st)
            S_ID:
              if (id_ok) begin
                drv <= 1'b1;
                st <= sh[0] ? S_TX : S_ADDR;
              end else begin
                st <= S_IDLE;
                ackph <= 1'b0;
              end
            S_ADDR: begin
              drv <= 1'b1; addr <= sh[AW-1:0]; st <= S_WDATA;
            end
            S_WDATA: begin
              drv <= 1'b1; wr_stb <= 1'b1; wr_addr <= addr; wr_data <= sh; st <= S_IDLE;
            end
            default: drv <= 1'b0;
          endcase
        end else if (st == S_TX) drv <= ~sh[7];
      end
    end
endmodule

module pinaddr_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic scl_f,
  input logic drv,
  input logic wr_stb,
  input logic stop_stb
);
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && drv != $past(drv)) |-> !scl_f)
    else $error("R11 SDA pull changed while SCL high");

  p_stop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !stop_stb)
    else $error("R7 stop strobe longer than one cycle");

  p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb)
    else $error("R3 write strobe longer than one cycle");

  p_quiet_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> (!drv && !wr_stb && !stop_stb))
    else $error("R8 activity while not ready");
endmodule

bind pinaddr_i2c_slave pinaddr_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .scl_f(scl_f),
  .drv(drv), .wr_stb(wr_stb), .stop_stb(stop_stb)
);

// File: tb/pinaddr_i2c_slave_bench.sv
`timescale 1ns/1ps
module pinaddr_i2c_slave_bench;
  localparam int Q = 80;

  logic clk = 1'b0, rst_n = 1'b0, ready = 1'b0;
  logic [1:0] strap = 2'b10;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, wr_stb, stop_stb;
  logic [1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] mem [4];
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0, wcnt = 0, scnt = 0;
  logic [1:0] lw_addr;
  logic [7:0] lw_data;

  always #2 clk = ~clk;
  assign rd_data = mem[rd_addr];

  pinaddr_i2c_slave u_pinaddr_i2c_slave (
    .clk(clk), .rst_n(rst_n), .ready(ready), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .stop_stb(stop_stb)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      wcnt++; lw_addr = wr_addr; lw_data = wr_data; mem[wr_addr] = wr_data;
    end
    if (stop_stb) scnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic m_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic m_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1'b1; #Q; scl_m = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl_m = 1'b1; #(Q/2); ack = ~sda_line; #(Q/2); scl_m = 1'b0; #Q;
  endtask

  task automatic m_rdbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl_m = 1'b1; #(Q/2); b[i] = sda_line; #(Q/2); scl_m = 1'b0;
    end
    #Q; sda_m = ~mack; #Q; scl_m = 1'b1; #Q; scl_m = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] id, a, d, output bit ai, aa, ad);
    m_start(); m_byte(id, ai); m_byte(a, aa); m_byte(d, ad); m_stop(); #(4*Q);
  endtask

  // {id, addr, data, expected id ack}
  localparam logic [24:0] VEC [6] = '{
    {8'h54, 8'h00, 8'hC3, 1'b1},
    {8'h54, 8'h01, 8'h5A, 1'b1},
    {8'h50, 8'h02, 8'hFF, 1'b0},
    {8'h54, 8'h02, 8'h81, 1'b1},
    {8'hD4, 8'h00, 8'h00, 1'b0},
    {8'h56, 8'h01, 8'h00, 1'b0}
  };

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ai, aa, ad, ax;
    int w0, s0;
    logic [7:0] rb;
    mem[0] = 8'h10; mem[1] = 8'h20; mem[2] = 8'h30; mem[3] = 8'h11;
    #1;
    #40; rst_n = 1'b1; #8;
    chk(sda_pull == 1'b0 && wr_stb == 1'b0 && stop_stb == 1'b0, "R10 reset state",
        {sda_pull, wr_stb, stop_stb}, 0);

    w0 = wcnt; s0 = scnt;
    wr_txn(8'h54, 8'h00, 8'hEE, ai, aa, ad);
    chk(!ai && !aa && !ad, "R8 no ack while not ready", {ai, aa, ad}, 0);
    chk(wcnt == w0 && scnt == s0, "R8 no strobes while not ready", wcnt - w0 + scnt - s0, 0);
    ready = 1'b1; #(4*Q);

    s0 = scnt;
    sda_m = 1'b0; #8; sda_m = 1'b1; #(4*Q);
    chk(scnt == s0, "R9 short SDA pulse ignored", scnt - s0, 0);
    sda_m = 1'b0; #Q; sda_m = 1'b1; #(4*Q);
    chk(scnt == s0 + 1, "R7 long pulse gives start and stop", scnt - s0, 1);

    for (int k = 0; k < 6; k++) begin
      w0 = wcnt; s0 = scnt;
      wr_txn(VEC[k][24:17], VEC[k][16:9], VEC[k][8:1], ai, aa, ad);
      chk(ai == VEC[k][0], "R1 R2 id ack", ai, VEC[k][0]);
      if (VEC[k][0]) begin
        chk(aa && ad, "R3 addr and data ack", {aa, ad}, 3);
        chk(wcnt == w0 + 1 && lw_addr == VEC[k][10:9] && lw_data == VEC[k][8:1],
            "R3 write commit", {lw_addr, lw_data}, {VEC[k][10:9], VEC[k][8:1]});
      end else begin
        chk(!aa && !ad && wcnt == w0, "R2 silent after mismatch", {aa, ad, wcnt - w0}, 0);
      end
      chk(scnt == s0 + 1, "R7 stop strobe", scnt - s0, 1);
    end
    chk(mem[2] == 8'h81, "R2 register untouched by mismatch", mem[2], 8'h81);

    w0 = wcnt;
    m_start(); m_byte(8'h54, ai); m_byte(8'h02, aa); m_byte(8'h66, ad); m_byte(8'h99, ax); m_stop(); #(4*Q);
    chk(ai && aa && ad && !ax, "R4 extra byte nacked", {ai, aa, ad, ax}, 4'b1110);
    chk(wcnt == w0 + 1 && mem[2] == 8'h66, "R4 one commit only", {wcnt - w0, mem[2]}, {32'd1, 8'h66});

    m_start(); m_byte(8'h54, ai); m_byte(8'h01, aa); m_start(); m_byte(8'h55, ad);
    chk(ai && aa && ad, "R5 read instruction acked", {ai, aa, ad}, 3'b111);
    m_rdbyte(1'b1, rb); chk(rb == 8'h5A, "R5 read byte at 1", rb, 8'h5A);
    m_rdbyte(1'b1, rb); chk(rb == 8'h66, "R5 read byte at 2", rb, 8'h66);
    m_rdbyte(1'b1, rb); chk(rb == 8'hC3, "R5 wrap to 0", rb, 8'hC3);
    m_rdbyte(1'b0, rb); chk(rb == 8'h5A, "R5 read byte at 1 again", rb, 8'h5A);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #(Q/2);
    chk(sda_line == 1'b1, "R6 released after nack", sda_line, 1);
    #(Q/2); scl_m = 1'b0; #Q; m_stop(); #(4*Q);

    strap = 2'b01; #(4*Q);
    w0 = wcnt;
    wr_txn(8'h52, 8'h00, 8'h44, ai, aa, ad);
    chk(ai && aa && ad && wcnt == w0 + 1 && lw_data == 8'h44, "R1 new strap accepted", lw_data, 8'h44);
    wr_txn(8'h54, 8'h00, 8'h77, ai, aa, ad);
    chk(!ai && wcnt == w0 + 1, "R1 old strap refused", ai, 0);

    m_start(); m_byte(8'h52, ai); m_byte(8'h00, aa); m_start(); m_byte(8'h53, ad);
    m_rdbyte(1'b0, rb); m_stop(); #(4*Q);
    chk(ai && aa && ad && rb == 8'h44, "R5 single byte read", rb, 8'h44);
    chk(sda_pull == 1'b0, "R6 bus idle released", sda_pull, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule